// File: doc/BRIEF.md
# Ten-Bit Compare Timer with Shared High-Bit Latch

This block is a 10-bit up-counter with four compare registers, reached through an 8-bit register bus. One of the four registers sets the terminal count. When the counter steps while it equals that value, it returns to zero and raises an overflow flag. Each of the other three compare channels raises its own match flag and toggles its own output pin whenever the counter steps past its value.

The bus moves eight bits at a time, so the two upper bits of every 10-bit register go through one shared 2-bit latch. To write, software loads the latch first and then writes the low byte; both parts land together in one clock. Reading any low byte copies that register's upper bits into the latch, so a read of the latch that follows returns bits that belong to the same value.

An 8-bit mode clears the upper bits out of every comparison and out of every write. Flags are cleared by writing 1 to them. A single interrupt line reports any flag whose mask bit is set.

Top module: `cmp_timer10`

## Requirements
- R1: After reset the count, channel compare values, latch, flags, control byte, pins and irq are all zero, and the terminal value is 0x3FF.
- R2: On each clock with `step` high, the count goes up by one. A step taken while the count equals the terminal value returns it to zero instead.
- R3: A low-byte write to the count (addr 0), compare A (addr 1), B (addr 2), D (addr 3) or terminal (addr 4) stores {latch, wdata} in a single clock. Addr 5 is the latch, held in wdata[1:0].
- R4: A step taken while the count equals the effective value of channel A, B or D sets that channel's flag and toggles `out_a`, `out_b` or `out_d`.
- R5: A read (rd_en) of any low byte at addr 0 to 4 loads that register's bits 9:8 into the latch on the same clock. `rdata` is combinational for the addressed register.
- R6: With control bit 4 set (8-bit mode), writes store zero in bits 9:8 whatever the latch holds, and every comparison treats bits 9:8 of the compare and terminal values as zero.
- R7: The flag byte (addr 6) has overflow at bit 0, A at bit 1, B at bit 2 and D at bit 3. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: `irq` is high exactly when some flag is set whose mask bit (control byte at addr 7, bits 3:0 in the same order as the flags) is also set.
- R9: The overflow flag sets on the clock at which the count returns from the terminal value to zero.
- R10: A bus write to the count takes priority over a step in the same clock, and no match or overflow arises from that step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Count enable for this clock |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (loads latch on wide reads) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational |
| out_a | output | 1 | Channel A toggle pin |
| out_b | output | 1 | Channel B toggle pin |
| out_d | output | 1 | Channel D toggle pin |
| irq | output | 1 | Masked OR of all flags |

## Verification
A corrupted latch shows up at the ports on the next wide write, because it puts wrong upper bits into a compare register. The effect then appears at the pins once the count reaches the misplaced value, which may be up to a full terminal period later. The bench therefore reads the latch back right after each wide read and checks its value directly. A wrong count, a wrong terminal value or a lost clear shows on the clock after the faulty step, as a wrong low-byte readback, a missing or early overflow flag, or a pin toggling at the wrong count. The bench checks these one clock after the step concerned.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    RA_CNT  = 3'd0,
    RA_CMPA = 3'd1,
    RA_CMPB = 3'd2,
    RA_CMPD = 3'd3,
    RA_TOP  = 3'd4,
    RA_HOLD = 3'd5,
    RA_FLAG = 3'd6,
    RA_CTRL = 3'd7
  } reg_addr_e;

  localparam int NUM_CH   = 3;
  localparam int FLAG_OVF = 0;
  localparam int CTRL_M8  = 4;

  function automatic logic [2:0] ch_addr(input int idx);
    return 3'(int'(RA_CMPA) + idx);
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int BUS_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [2:0]                     addr,
  input  logic [BUS_W-1:0]               wdata,
  input  logic                           mode8,
  input  logic [CNT_W-1:0]               cnt_val,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_q,
  output logic [CNT_W-1:0]               top_q,
  output logic [CNT_W-BUS_W-1:0]         hold_q,
  output logic                           cnt_load,
  output logic [CNT_W-1:0]               cnt_load_val
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] wide_val;
  logic [CNT_W-1:0] rd_src;
  logic             rd_wide;

  assign wide_val     = mode8 ? {{HI_W{1'b0}}, wdata} : {hold_q, wdata};
  assign cnt_load     = wr_en && (addr == RA_CNT);
  assign cnt_load_val = wide_val;

  always_comb begin
    rd_wide = 1'b1;
    rd_src  = '0;
    case (addr)
      RA_CNT:  rd_src = cnt_val;
      RA_CMPA: rd_src = cmp_q[0];
      RA_CMPB: rd_src = cmp_q[1];
      RA_CMPD: rd_src = cmp_q[2];
      RA_TOP:  rd_src = top_q;
      default: rd_wide = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_q <= '0;
    else if (wr_en && addr == RA_HOLD)
      hold_q <= wdata[HI_W-1:0];
    else if (rd_en && !wr_en && rd_wide)
      hold_q <= rd_src[CNT_W-1:BUS_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      top_q <= '1;
    else if (wr_en && addr == RA_TOP)
      top_q <= wide_val;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n)
        cmp_q[g] <= '0;
      else if (wr_en && addr == ch_addr(g))
        cmp_q[g] <= wide_val;
    end
  end

  AST_WIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CMPA && !mode8) |=> cmp_q[0] == {$past(hold_q), $past(wdata)}); // R3
  AST_NARROW_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_TOP && mode8) |=> top_q[CNT_W-1:BUS_W] == '0); // R6
  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == RA_CNT) |=> hold_q == $past(cnt_val[CNT_W-1:BUS_W])); // R5
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] top_eff,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  assign wrap = step && !load && (cnt_q == top_eff);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (step)
      cnt_q <= (cnt_q == top_eff) ? '0 : cnt_q + 1'b1;
  end

  AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q == top_eff) |=> cnt_q == '0); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val)); // R10
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_eff,
  output logic             hit,
  output logic             pin
);
  assign hit = step && !load && (cnt == cmp_eff);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pin <= 1'b0;
    else if (hit)
      pin <= !pin;
  end

  AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pin != $past(pin)); // R4
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(pin)); // R4
endmodule

// File: rtl/cmp_timer10.sv
module cmp_timer10
  import tmr_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             out_a,
  output logic             out_b,
  output logic             out_d,
  output logic             irq
);
  localparam int HI_W   = CNT_W - BUS_W;
  localparam int NFLAGS = NUM_CH + 1;

  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]             top_q, top_eff, cnt_q, load_val;
  logic [HI_W-1:0]              hold_q;
  logic                         cnt_load, wrap, mode8;
  logic [NUM_CH-1:0]            hit, pins;
  logic [NFLAGS-1:0]            flags, mask, set_ev;

  tmr_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .mode8(mode8), .cnt_val(cnt_q), .cmp_q(cmp_q),
    .top_q(top_q), .hold_q(hold_q), .cnt_load(cnt_load),
    .cnt_load_val(load_val)
  );

  assign top_eff = mode8 ? {{HI_W{1'b0}}, top_q[BUS_W-1:0]} : top_q;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(cnt_load),
    .load_val(load_val), .top_eff(top_eff), .cnt_q(cnt_q), .wrap(wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CNT_W-1:0] cmp_eff;
    assign cmp_eff = mode8 ? {{HI_W{1'b0}}, cmp_q[g][BUS_W-1:0]} : cmp_q[g];
    tmr_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .step(step), .load(cnt_load),
      .cnt(cnt_q), .cmp_eff(cmp_eff), .hit(hit[g]), .pin(pins[g])
    );
  end

  assign out_a  = pins[0];
  assign out_b  = pins[1];
  assign out_d  = pins[2];
  assign set_ev = {hit, wrap};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= '0;
      mode8 <= 1'b0;
    end else if (wr_en && addr == RA_CTRL) begin
      mask  <= wdata[NFLAGS-1:0];
      mode8 <= wdata[CTRL_M8];
    end
  end

  for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[f] <= 1'b0;
      else if (set_ev[f])
        flags[f] <= 1'b1;
      else if (wr_en && addr == RA_FLAG && wdata[f])
        flags[f] <= 1'b0;
    end
  end

  assign irq = |(flags & mask);

  always_comb begin
    case (addr)
      RA_CNT:  rdata = cnt_q[BUS_W-1:0];
      RA_CMPA: rdata = cmp_q[0][BUS_W-1:0];
      RA_CMPB: rdata = cmp_q[1][BUS_W-1:0];
      RA_CMPD: rdata = cmp_q[2][BUS_W-1:0];
      RA_TOP:  rdata = top_q[BUS_W-1:0];
      RA_HOLD: rdata = BUS_W'(hold_q);
      RA_FLAG: rdata = BUS_W'(flags);
      default: rdata = BUS_W'({mode8, mask});
    endcase
  end

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[FLAG_OVF]); // R9
  AST_W1C_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_FLAG && wdata[1] && !hit[0]) |=> !flags[1]); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq); // R8
  AST_LOAD_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load && !flags[FLAG_OVF]) |=> !flags[FLAG_OVF]); // R10
endmodule

// File: tb/sim_cmp_timer10.sv
module sim_cmp_timer10;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       out_a, out_b, out_d, irq;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       pa, pb, pd;

  always #10 clk = ~clk;

  cmp_timer10 u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .out_a(out_a),
    .out_b(out_b), .out_d(out_d), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    step = 1'b1;
    repeat (n) @(negedge clk);
    step = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd0, v); chk("R1 count", v, 0);
    rd(3'd6, v); chk("R1 flags", v, 0);
    chk("R1 irq/pins", {irq, out_a, out_b, out_d}, 0);
    rd(3'd4, v); chk("R1 terminal low", v, 8'hFF);
    rd(3'd5, v); chk("R1 terminal high via latch", v, 3);
  endtask

  task automatic t_wide_write();
    logic [7:0] v;
    wr(3'd5, 8'h02); wr(3'd1, 8'h34);
    rd(3'd1, v); chk("R3 cmpA low", v, 8'h34);
    wr(3'd5, 8'h00);
    rd(3'd1, v);
    rd(3'd5, v); chk("R3 cmpA high via R5 latch", v, 2);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    wr(3'd5, 8'h00); wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd6, 8'h0F);
    run(5);
    rd(3'd0, v); chk("R2 count at terminal", v, 5);
    rd(3'd6, v); chk("R9 no overflow yet", v & 1, 0);
    run(1);
    rd(3'd0, v); chk("R2 cleared at terminal", v, 0);
    rd(3'd6, v); chk("R9 overflow set", v, 8'h0D);
    chk("R8 irq unmasked off", irq, 0);
    wr(3'd7, 8'h01); chk("R8 irq masked on", irq, 1);
    wr(3'd6, 8'h01);
    rd(3'd6, v); chk("R7 clear only bit0", v, 8'h0C);
    chk("R8 irq after clear", irq, 0);
    wr(3'd6, 8'h0F); wr(3'd7, 8'h00);
  endtask

  task automatic t_match();
    logic [7:0] v;
    wr(3'd5, 8'h00); wr(3'd1, 8'h03);
    wr(3'd5, 8'h01); wr(3'd2, 8'h04);
    wr(3'd5, 8'h00); wr(3'd3, 8'h04);
    wr(3'd0, 8'h00); wr(3'd6, 8'h0F);
    pa = out_a; pb = out_b; pd = out_d;
    run(3);
    rd(3'd6, v); chk("R4 no early match", v, 0);
    run(1);
    rd(3'd6, v); chk("R4 flag A", v, 8'h02);
    chk("R4 out_a toggled", out_a, int'(!pa));
    run(1);
    rd(3'd6, v); chk("R4 flag D, B high bits differ", v, 8'h0A);
    chk("R4 out_d toggled", out_d, int'(!pd));
    chk("R4 out_b held", out_b, int'(pb));
  endtask

  task automatic t_latch_load();
    logic [7:0] v;
    wr(3'd5, 8'h02); wr(3'd0, 8'h80);
    wr(3'd5, 8'h00);
    rd(3'd0, v); chk("R5 count low", v, 8'h80);
    rd(3'd5, v); chk("R5 count high in latch", v, 2);
    wr(3'd5, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = 8'h11; step = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; step = 1'b0;
    rd(3'd0, v); chk("R10 write beats step", v, 8'h11);
    rd(3'd5, v); chk("R10 written high bits", v, 1);
    run(2);
    rd(3'd0, v); chk("R2 counts after load", v, 8'h13);
  endtask

  task automatic t_mode8();
    logic [7:0] v;
    wr(3'd7, 8'h10);
    wr(3'd5, 8'h03); wr(3'd1, 8'h07);
    rd(3'd1, v); chk("R6 cmpA low", v, 8'h07);
    rd(3'd5, v); chk("R6 latch ignored on write", v, 0);
    wr(3'd5, 8'h03); wr(3'd0, 8'h00); wr(3'd6, 8'h0F);
    run(5);
    rd(3'd6, v); chk("R6 B matches with high bits dropped", v, 8'h0C);
    run(1);
    rd(3'd6, v); chk("R6 R9 wrap at narrowed terminal", v, 8'h0D);
    rd(3'd0, v); chk("R6 count zero", v, 0);
  endtask

  task automatic t_mask();
    wr(3'd7, 8'h12); chk("R8 irq with only A masked", irq, 0);
    wr(3'd7, 8'h14); chk("R8 irq with B masked", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide_write();
    t_wrap();
    t_match();
    t_latch_load();
    t_mode8();
    t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule